// File: doc/BRIEF.md
# Shared Forward/Inverse Byte Substitution Unit

This block performs the cipher byte substitution in either direction on one byte. A direction input picks forward or inverse substitution. Both directions share a single multiplicative-inverse core in GF(2^8). For the forward direction, the inverse is taken first and the forward affine map is applied after it. For the inverse direction, the inverse affine map is applied first and the inverse is taken after it. Two multiplexers, one on each side of the core, steer the byte through the correct affine step.

The field inverse is not read from a table. The byte is first mapped into a tower of degree-two extensions over GF(2). The levels are GF(2^2) with x^2+x+1, then GF(2^4) with y^2+y+φ where φ = binary 10, then GF(2^8) with z^2+z+λ where λ = binary 1100. Inversion at the top level uses A^-1 = (A^17)^-1·A^16. Because A^17 is an element of the 4-bit subfield, only a GF(2^4) inverse has to be built in gates. The result is then mapped back to the standard byte field. Both change-of-basis matrices are computed at elaboration from a root of the field polynomial x^8+x^4+x^3+x+1 found in the tower.

The parameter REG_OUT chooses the output timing. When it is 1, which is the default, the result is held in an output register that resets asynchronously. When it is 0, the result is purely combinational.

Top module: `dual_sbox`

## Requirements
- R1: With decSel = 0, outByte is the forward substitution of the input. This is F(inv(a)), where inv is the GF(2^8) inverse modulo x^8+x^4+x^3+x+1 (with inv(0) = 0), and F(b) = b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 0x63.
- R2: With decSel = 1, outByte is the inverse substitution of the input. This is inv(G(a)), where G(s) = rotl(s,1) ^ rotl(s,3) ^ rotl(s,6) ^ 0x05.
- R3: In forward mode the input 0x00 produces 0x63, because zero inverts to zero.
- R4: In inverse mode the input 0x63 produces 0x00.
- R5: For every byte a, the inverse-mode result of the forward-mode result of a equals a.
- R6: In either mode the result never equals the input and never equals the bitwise complement of the input.
- R7: With REG_OUT = 1, the result for the inByte and decSel values sampled at a rising clock edge appears on outByte just after that edge. The result stays unchanged until the next rising edge, whatever the inputs do in between. A change of decSel alone takes effect on the same schedule as a change of data.
- R8: With REG_OUT = 1, holding rstN low forces outByte to 0x00 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low asynchronous reset of the output register |
| inByte | input | 8 | Byte to substitute |
| decSel | input | 1 | 0 selects forward substitution, 1 selects inverse substitution |
| outByte | output | 8 | Substituted byte |

## Verification
In the default registered build, a result is due one rising edge after its operand. The bench therefore changes inByte and decSel on the falling edge and reads outByte on the next falling edge. That leaves exactly one register load in between. For R7, the bench changes the inputs shortly after a falling edge and confirms that outByte still shows the previous result before the next rising edge. For R8, reset is asserted between edges and the output is read a moment later, with no clock edge in between. The checker aligns every property with the same one-edge delay: it keeps its own copies of the inputs from the previous one and two edges, plus a count of edges since reset.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

  typedef struct packed {
    logic preInvAffine;   // steer the inverse affine map ahead of the inverter
    logic postFwdAffine;  // steer the forward affine map behind the inverter
    logic loadOut;        // output register capture strobe
  } sboxStrobes_t;

  localparam logic [1:0] PHI    = 2'b10;
  localparam logic [3:0] LAMBDA = 4'b1100;

  // GF(2^2), basis {x,1}, x^2 = x + 1
  function automatic logic [1:0] gf4Mul(input logic [1:0] a, input logic [1:0] b);
    logic hh;
    hh = a[1] & b[1];
    return {hh ^ (a[1] & b[0]) ^ (a[0] & b[1]), hh ^ (a[0] & b[0])};
  endfunction

  // inverse in GF(2^2) equals squaring for nonzero elements, 0 -> 0
  function automatic logic [1:0] gf4Inv(input logic [1:0] a);
    return {a[1], a[1] ^ a[0]};
  endfunction

  // GF((2^2)^2), y^2 = y + PHI
  function automatic logic [3:0] gf16Mul(input logic [3:0] a, input logic [3:0] b);
    logic [1:0] hh;
    hh = gf4Mul(a[3:2], b[3:2]);
    return {hh ^ gf4Mul(a[3:2], b[1:0]) ^ gf4Mul(a[1:0], b[3:2]),
            gf4Mul(hh, PHI) ^ gf4Mul(a[1:0], b[1:0])};
  endfunction

  // GF(((2^2)^2)^2), z^2 = z + LAMBDA; used only to derive the basis change
  function automatic logic [7:0] gf256TowerMul(input logic [7:0] a, input logic [7:0] b);
    logic [3:0] hh;
    hh = gf16Mul(a[7:4], b[7:4]);
    return {hh ^ gf16Mul(a[7:4], b[3:0]) ^ gf16Mul(a[3:0], b[7:4]),
            gf16Mul(hh, LAMBDA) ^ gf16Mul(a[3:0], b[3:0])};
  endfunction

  // first tower element that is a root of x^8+x^4+x^3+x+1
  function automatic logic [7:0] findRoot();
    logic [7:0] pw [0:8];
    logic [7:0] res;
    logic       found;
    res   = 8'h00;
    found = 1'b0;
    for (int c = 1; c < 256; c++) begin
      pw[0] = 8'h01;
      for (int k = 1; k <= 8; k++) pw[k] = gf256TowerMul(pw[k-1], c[7:0]);
      if (!found && ((pw[8] ^ pw[4] ^ pw[3] ^ pw[1] ^ pw[0]) == 8'h00)) begin
        res   = c[7:0];
        found = 1'b1;
      end
    end
    return res;
  endfunction

  // columns of a GF(2) matrix: result = XOR of cols[i] where v[i] is set
  function automatic logic [7:0] applyMap(input logic [7:0][7:0] cols, input logic [7:0] v);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 0; i < 8; i++) if (v[i]) r = r ^ cols[i];
    return r;
  endfunction

  function automatic logic [7:0][7:0] buildToTower();
    logic [7:0][7:0] cols;
    logic [7:0]      g;
    logic [7:0]      p;
    g = findRoot();
    p = 8'h01;
    for (int i = 0; i < 8; i++) begin
      cols[i] = p;
      p = gf256TowerMul(p, g);
    end
    return cols;
  endfunction

  function automatic logic [7:0][7:0] buildFromTower(input logic [7:0][7:0] toCols);
    logic [7:0][7:0] cols;
    cols = '0;
    for (int j = 0; j < 8; j++)
      for (int b = 0; b < 256; b++)
        if (applyMap(toCols, b[7:0]) == (8'h01 << j)) cols[j] = b[7:0];
    return cols;
  endfunction

  localparam logic [7:0][7:0] TO_TOWER   = buildToTower();
  localparam logic [7:0][7:0] FROM_TOWER = buildFromTower(TO_TOWER);

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] fwdAffine(input logic [7:0] b);
    return b ^ rotl8(b, 1) ^ rotl8(b, 2) ^ rotl8(b, 3) ^ rotl8(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] invAffine(input logic [7:0] s);
    return rotl8(s, 1) ^ rotl8(s, 3) ^ rotl8(s, 6) ^ 8'h05;
  endfunction

endpackage

// File: rtl/gf16_inverter.sv
module gf16_inverter
  import sbox_pkg::*;
(
  input  logic [3:0] aVal,
  output logic [3:0] invVal
);
  logic [1:0] aHi, aLo, hiSq, normVal, normInv;

  assign aHi = aVal[3:2];
  assign aLo = aVal[1:0];

  always_comb begin
    hiSq    = gf4Mul(aHi, aHi);
    // norm over GF(2^2): PHI*aHi^2 + (aHi+aLo)*aLo
    normVal = gf4Mul(hiSq, PHI) ^ gf4Mul(aHi ^ aLo, aLo);
    normInv = gf4Inv(normVal);
    invVal  = {gf4Mul(normInv, aHi), gf4Mul(normInv, aHi ^ aLo)};
  end
endmodule

// File: rtl/tower_inverter.sv
module tower_inverter
  import sbox_pkg::*;
(
  input  logic [7:0] aByte,
  output logic [7:0] invByte
);
  logic [7:0] towerA;
  logic [3:0] aHi, aLo, hiSq, normVal, normInv;
  logic [7:0] towerInv;

  // stage 1: into the composite field
  assign towerA = applyMap(TO_TOWER, aByte);
  assign aHi    = towerA[7:4];
  assign aLo    = towerA[3:0];

  // stage 2: A^17 = LAMBDA*aHi^2 + (aHi+aLo)*aLo lies in GF(2^4)
  always_comb begin
    hiSq    = gf16Mul(aHi, aHi);
    normVal = gf16Mul(hiSq, LAMBDA) ^ gf16Mul(aHi ^ aLo, aLo);
  end

  gf16_inverter u_subInv (
    .aVal  (normVal),
    .invVal(normInv)
  );

  // (A^17)^-1 * A^16, with A^16 = aHi*z + (aHi+aLo)
  assign towerInv = {gf16Mul(normInv, aHi), gf16Mul(normInv, aHi ^ aLo)};

  // stage 3: back to the byte field
  assign invByte = applyMap(FROM_TOWER, towerInv);
endmodule

// File: rtl/sbox_ctrl.sv
module sbox_ctrl
  import sbox_pkg::*;
(
  input  logic         decSel,
  output sboxStrobes_t strobes
);
  always_comb begin
    strobes.preInvAffine  = decSel;
    strobes.postFwdAffine = ~decSel;
    strobes.loadOut       = 1'b1;
  end
endmodule

// File: rtl/sbox_datapath.sv
module sbox_datapath
  import sbox_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [7:0]   inByte,
  input  sboxStrobes_t strobes,
  output logic [7:0]   outByte
);
  logic [7:0] preByte, invRes, postByte;

  assign preByte = strobes.preInvAffine ? invAffine(inByte) : inByte;

  tower_inverter u_inv (
    .aByte  (preByte),
    .invByte(invRes)
  );

  assign postByte = strobes.postFwdAffine ? fwdAffine(invRes) : invRes;

  generate
    if (REG_OUT != 0) begin : g_reg
      logic [7:0] outReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                outReg <= 8'h00;
        else if (strobes.loadOut) outReg <= postByte;
      end
      assign outByte = outReg;
    end else begin : g_comb
      assign outByte = postByte;
    end
  endgenerate
endmodule

// File: rtl/dual_sbox.sv
module dual_sbox
  import sbox_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inByte,
  input  logic       decSel,
  output logic [7:0] outByte
);
  sboxStrobes_t strobes;

  sbox_ctrl u_ctrl (
    .decSel (decSel),
    .strobes(strobes)
  );

  sbox_datapath #(.REG_OUT(REG_OUT)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .inByte (inByte),
    .strobes(strobes),
    .outByte(outByte)
  );
endmodule

// File: rtl/dual_sbox_chk.sv
module dual_sbox_chk
  import sbox_pkg::*;
#(
  parameter int REG_OUT = 1
) (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] inByte,
  input logic       decSel,
  input logic [7:0] outByte
);
  logic [1:0] edgeCnt;
  logic [7:0] prevIn, prev2In;
  logic       prevDec, prev2Dec;
  logic [7:0] alignedIn;
  logic       alignedDec, alignedOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt  <= 2'd0;
      prevIn   <= 8'h00;
      prev2In  <= 8'h00;
      prevDec  <= 1'b0;
      prev2Dec <= 1'b0;
    end else begin
      if (edgeCnt != 2'd3) edgeCnt <= edgeCnt + 2'd1;
      prevIn   <= inByte;
      prev2In  <= prevIn;
      prevDec  <= decSel;
      prev2Dec <= prevDec;
    end
  end

  assign alignedIn  = (REG_OUT != 0) ? prevIn  : inByte;
  assign alignedDec = (REG_OUT != 0) ? prevDec : decSel;
  assign alignedOk  = (REG_OUT != 0) ? (edgeCnt != 2'd0) : 1'b1;

  initial begin
    for (int v = 0; v < 256; v++) begin
      AST_MAP_ROUNDTRIP: assert (applyMap(FROM_TOWER, applyMap(TO_TOWER, v[7:0])) == v[7:0]) else $error("basis change not invertible at %0d", v); // R1
    end
  end

  AST_ENC_ZERO: assert property (@(posedge clk) disable iff (!rstN) (alignedOk && !alignedDec && alignedIn == 8'h00) |-> outByte == 8'h63) else $error("zero not mapped to 0x63"); // R3
  AST_DEC_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN) (alignedOk && alignedDec && alignedIn == 8'h63) |-> outByte == 8'h00) else $error("0x63 not mapped to zero"); // R4
  AST_ENC_NO_FIXED: assert property (@(posedge clk) disable iff (!rstN) (alignedOk && !alignedDec) |-> (outByte != alignedIn && outByte != ~alignedIn)) else $error("forward fixed point"); // R6
  AST_DEC_NO_FIXED: assert property (@(posedge clk) disable iff (!rstN) (alignedOk && alignedDec) |-> (outByte != alignedIn && outByte != ~alignedIn)) else $error("inverse fixed point"); // R6
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN) (REG_OUT != 0 && edgeCnt >= 2'd2 && prevIn == prev2In && prevDec == prev2Dec) |-> $stable(outByte)) else $error("output moved with steady inputs"); // R7

  always @(negedge clk) begin
    if (REG_OUT != 0 && !rstN) begin
      AST_RESET_CLEAR: assert (outByte == 8'h00) else $error("output not cleared in reset"); // R8
    end
  end
endmodule

bind dual_sbox dual_sbox_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .inByte (inByte),
  .decSel (decSel),
  .outByte(outByte)
);

// File: tb/tb_dual_sbox.sv
`timescale 1ns/1ps
module tb_dual_sbox;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic       decSel = 1'b0;
  logic [7:0] outByte;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [7:0] encOut [0:255];

  always #5 clk = ~clk;

  dual_sbox #(.REG_OUT(1)) dut (
    .clk(clk), .rstN(rstN), .inByte(inByte), .decSel(decSel), .outByte(outByte)
  );

  function automatic logic [7:0] refMul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x, y;
    p = 8'h00; x = a; y = b;
    for (int i = 0; i < 8; i++) begin
      if (y[0]) p = p ^ x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] refInv(input logic [7:0] a);
    logic [7:0] r, base;
    logic [7:0] e;
    r = 8'h01; base = a; e = 8'd254;
    for (int i = 0; i < 8; i++) begin
      if (e[i]) r = refMul(r, base);
      base = refMul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] refFwd(input logic [7:0] a);
    logic [7:0] b;
    b = refInv(a);
    return b ^ rl(b, 1) ^ rl(b, 2) ^ rl(b, 3) ^ rl(b, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] refRev(input logic [7:0] a);
    return refInv(rl(a, 1) ^ rl(a, 3) ^ rl(a, 6) ^ 8'h05);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic checkNot(input string req, input logic [7:0] act, input logic [7:0] bad);
    compared++;
    if (act === bad) begin
      mismatched++;
      $display("FAIL %s actual=%02h expected not %02h", req, act, bad);
    end
  endtask

  // called at a falling edge; result read at the following falling edge
  task automatic step(input logic [7:0] a, input logic d, output logic [7:0] y);
    inByte = a;
    decSel = d;
    @(negedge clk);
    y = outByte;
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    logic [7:0] y, held;
    repeat (3) @(negedge clk);
    check("R8 reset value", outByte, 8'h00);
    rstN = 1'b1;

    // R1, R3, R6: forward sweep
    for (int a = 0; a < 256; a++) begin
      step(a[7:0], 1'b0, y);
      encOut[a] = y;
      check((a == 0) ? "R3 zero" : "R1 forward", y, refFwd(a[7:0]));
      checkNot("R6 forward fixed", y, a[7:0]);
      checkNot("R6 forward complement", y, ~a[7:0]);
    end

    // R2, R4, R6: inverse sweep
    for (int a = 0; a < 256; a++) begin
      step(a[7:0], 1'b1, y);
      check((a == 8'h63) ? "R4 0x63" : "R2 inverse", y, refRev(a[7:0]));
      checkNot("R6 inverse fixed", y, a[7:0]);
      checkNot("R6 inverse complement", y, ~a[7:0]);
    end

    // R5: inverse of forward result returns the byte
    for (int a = 0; a < 256; a++) begin
      step(encOut[a], 1'b1, y);
      check("R5 round trip", y, a[7:0]);
    end

    // R7: registered timing and mode switch on steady data
    step(8'h53, 1'b0, held);
    check("R7 setup", held, refFwd(8'h53));
    #2;
    inByte = 8'hca;
    decSel = 1'b1;
    #2;
    check("R7 hold before edge", outByte, held);
    @(negedge clk);
    check("R7 new after edge", outByte, refRev(8'hca));
    step(8'hca, 1'b0, y);
    check("R7 mode switch", y, refFwd(8'hca));

    // R8: asynchronous reset between edges
    step(8'h11, 1'b0, y);
    #2;
    rstN = 1'b0;
    #1;
    check("R8 async clear", outByte, 8'h00);
    @(negedge clk);
    check("R8 held in reset", outByte, 8'h00);
    rstN = 1'b1;
    step(8'h11, 1'b0, y);
    check("R8 recovery", y, refFwd(8'h11));

    done = 1'b1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      report();
    end
  end
endmodule